// File: doc/BRIEF.md
# Predicated Structure Memory Beat Unit

This unit carries out a single memory beat of a multi-register structure load or store. A structure access of N registers (N from 2 to 4) is split into N beats, and each beat moves one whole vector-sized contiguous block. The caller gives the beat its part index r, the register count N, the element size, a base address, and either a scaled register offset or a signed immediate. It also gives a per-element predicate and, for a store, the vector of data to write. The unit forms the block address, raises a single request with per-byte enables, and for a load returns the fetched vector with inactive elements cleared.

Predicates apply per structure, not per element position. The elements of all N registers are laid out in memory in interleaved order. The bit that governs element i of beat r is therefore the bit of the structure that element belongs to, which is (r*eCount + i)/N. Address alignment is not checked, and the unit reports no faults.

Top module: `struct_beat_unit`

## Requirements
- R1: While reset is held, and after it is released with no command given, `busy`, `req_valid` and `res_valid` are 0.
- R2: In immediate form (`op_use_imm`=1), `req_addr` = base + r*VLEN_BYTES + sext(imm)*VLEN_BYTES, modulo 2^AW.
- R3: In register form (`op_use_imm`=0), `req_addr` = base + r*VLEN_BYTES + offset*E. E is the element size in bytes, and `op_esz` codes 0,1,2,3 select 1,2,4,8 bytes.
- R4: `req_size` always equals VLEN_BYTES, which is eCount*E with eCount = VLEN_BYTES/E. Unaligned addresses are issued unchanged.
- R5: Element i of the beat, covering bytes i*E to i*E+E-1, is active when `op_pred` bit (r*eCount+i)/N is 1. `op_nregs` carries N as the plain value 2, 3 or 4.
- R6: On a load, `res_data` holds the response bytes of active elements and zero for every byte of inactive elements. `req_be` marks the active bytes.
- R7: On a store (`op_store`=1), `req_write`=1. `req_be` is 1 on every byte of an active element and 0 on every byte of an inactive one. `req_wdata` carries the store data on active bytes and zero on inactive bytes.
- R8: A request stays valid with stable address, enables, data and direction until `req_ready` is seen. It drops in the next cycle. Only one request is outstanding, and `busy` stays high until the result is delivered.
- R9: `res_valid` pulses for exactly one cycle, in the cycle after `resp_valid` is seen for an issued request. `res_data` is zero after a store. A `start` given while `busy` is high is ignored.
- R10: `resp_valid` given while no request is outstanding produces no result.
- R11: A new `start` is accepted in the same cycle that `res_valid` is high, and its request follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a beat with the op_* fields (taken when not busy) |
| op_store | input | 1 | 1 = store beat, 0 = load beat |
| op_use_imm | input | 1 | 1 = immediate offset form, 0 = register offset form |
| op_esz | input | 2 | Element size code (0..3 = 1,2,4,8 bytes) |
| op_nregs | input | 3 | Registers per structure N (2, 3 or 4) |
| op_part | input | 2 | Beat index r, 0..N-1 |
| op_base | input | AW | Base address |
| op_offset | input | AW | Offset register value, in elements |
| op_imm | input | IMM_W | Signed immediate, in vector blocks |
| op_pred | input | VLEN_BYTES | Governing predicate, one bit per element slot |
| op_wdata | input | 8*VLEN_BYTES | Store data for this beat |
| busy | output | 1 | A beat is in progress |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_write | output | 1 | Request is a write |
| req_addr | output | AW | Request byte address |
| req_size | output | $clog2(VLEN_BYTES)+1 | Request size in bytes |
| req_wdata | output | 8*VLEN_BYTES | Write data, zero on inactive bytes |
| req_be | output | VLEN_BYTES | Per-byte enables |
| resp_valid | input | 1 | Memory response valid |
| resp_rdata | input | 8*VLEN_BYTES | Memory read data |
| res_valid | output | 1 | Beat result valid (one cycle) |
| res_data | output | 8*VLEN_BYTES | Predicated load result |

## Verification
Two events can fall in one cycle: delivery of a finished beat's result and acceptance of the next beat's command. The bench provokes this by raising `start` with a new command in exactly the cycle where it observes `res_valid` for the previous load. It then judges two things. The delivered data must match the earlier command's predicate and response, and the next cycle's request must carry the new command's address and enables. It also raises `start` during an outstanding beat and `resp_valid` while idle, and confirms that neither produces a request or a result.

// File: rtl/struct_beat_pkg.sv
// Package: shared state type and divider helper for the structure beat unit.
// Assumes register counts of 2, 3 or 4; other counts pass the value through.
package struct_beat_pkg;

    typedef enum logic [1:0] {
        BEAT_IDLE = 2'd0,
        BEAT_REQ  = 2'd1,
        BEAT_WAIT = 2'd2
    } beat_state_e;

    // Quotient of a slot number by the register count of the structure.
    function automatic logic [15:0] div_by_count(input logic [15:0] num,
                                                 input logic [2:0]  cnt);
        logic [15:0] q;
        case (cnt)
            3'd2:    q = num >> 1;
            3'd3:    q = num / 16'd3;
            3'd4:    q = num >> 2;
            default: q = num;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/sbu_addr_gen.sv
// Address generator: forms the byte address of one vector-sized block.
// The part term and the immediate term are scaled by the vector length.
// The register offset is scaled by the element size.
// Assumes VLEN_BYTES is a power of two and AW > IMM_W.
module sbu_addr_gen #(
    parameter int AW         = 32,
    parameter int IMM_W      = 6,
    parameter int VLEN_BYTES = 16
) (
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    offset,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    input  logic [1:0]       esz,
    input  logic [1:0]       part,
    output logic [AW-1:0]    addr
);
    localparam int VSHIFT = $clog2(VLEN_BYTES);

    logic [AW-1:0] part_term;
    logic [AW-1:0] imm_term;
    logic [AW-1:0] reg_term;

    // Block position of this beat inside the structure group.
    assign part_term = AW'(part) << VSHIFT;
    // Signed immediate counted in whole vector blocks.
    assign imm_term  = {{(AW-IMM_W){imm[IMM_W-1]}}, imm} << VSHIFT;
    // Register offset counted in elements.
    assign reg_term  = offset << esz;
    // Final sum, wrapping modulo 2^AW.
    assign addr      = base + part_term + (use_imm ? imm_term : reg_term);

endmodule

// File: rtl/sbu_pred_map.sv
// Predicate mapper: selects the governing predicate bit of every element
// by structure number (r*eCount + i)/N and widens it to a byte mask.
// Assumes part < nregs; an out-of-range index yields an inactive element.
module sbu_pred_map
    import struct_beat_pkg::*;
#(
    parameter int VLEN_BYTES = 16
) (
    input  logic [VLEN_BYTES-1:0] pred,
    input  logic [1:0]            esz,
    input  logic [2:0]            nregs,
    input  logic [1:0]            part,
    output logic [VLEN_BYTES-1:0] byte_act
);
    localparam int IDX_W = $clog2(VLEN_BYTES);
    localparam int NUM_W = $clog2(4 * VLEN_BYTES) + 1;

    logic [NUM_W-1:0]      ecount;
    logic [VLEN_BYTES-1:0] elem_act;

    // Elements in one vector at the current element size.
    assign ecount = NUM_W'(VLEN_BYTES) >> esz;

    genvar e;
    generate
        for (e = 0; e < VLEN_BYTES; e++) begin : g_elem
            logic [NUM_W-1:0] slot;
            logic [15:0]      sidx;
            // Interleaved slot number of element e in the whole group.
            assign slot = NUM_W'(part) * ecount + NUM_W'(e);
            // Structure the slot belongs to.
            assign sidx = div_by_count(16'(slot), nregs);
            // Governing bit taken from that structure's predicate slot.
            assign elem_act[e] = (sidx < 16'(VLEN_BYTES)) ? pred[sidx[IDX_W-1:0]] : 1'b0;
        end
    endgenerate

    genvar b;
    generate
        for (b = 0; b < VLEN_BYTES; b++) begin : g_byte
            // Byte inherits the state of the element that contains it.
            assign byte_act[b] = elem_act[IDX_W'(b) >> esz];
        end
    endgenerate

endmodule

// File: rtl/sbu_lane_merge.sv
// Lane merge: applies the byte mask to the outgoing store data and to the
// returned load data. Inactive bytes become zero on both paths.
module sbu_lane_merge #(
    parameter int VLEN_BYTES = 16
) (
    input  logic [VLEN_BYTES-1:0]   byte_act,
    input  logic [8*VLEN_BYTES-1:0] st_in,
    input  logic [8*VLEN_BYTES-1:0] ld_in,
    output logic [8*VLEN_BYTES-1:0] st_out,
    output logic [8*VLEN_BYTES-1:0] ld_out
);
    genvar b;
    generate
        for (b = 0; b < VLEN_BYTES; b++) begin : g_lane
            // Store byte kept only when its element is active.
            assign st_out[8*b +: 8] = byte_act[b] ? st_in[8*b +: 8] : 8'h00;
            // Load byte kept only when its element is active.
            assign ld_out[8*b +: 8] = byte_act[b] ? ld_in[8*b +: 8] : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/sbu_ctrl.sv
// Beat sequencer: idle -> request -> wait for response -> idle.
// Allows one outstanding request. The result strobe is registered, so it
// is high in the cycle after the response, when the FSM is already idle.
module sbu_ctrl
    import struct_beat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic req_ready,
    input  logic resp_valid,
    output logic accept,
    output logic resp_take,
    output logic req_valid,
    output logic busy,
    output logic res_valid
);
    beat_state_e state;

    // Handshake decodes from the current state.
    assign accept    = (state == BEAT_IDLE) && start;
    assign resp_take = (state == BEAT_WAIT) && resp_valid;
    assign req_valid = (state == BEAT_REQ);
    assign busy      = (state != BEAT_IDLE);

    // State advance and result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= BEAT_IDLE;
            res_valid <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                BEAT_IDLE: if (start)      state <= BEAT_REQ;
                BEAT_REQ:  if (req_ready)  state <= BEAT_WAIT;
                BEAT_WAIT: if (resp_valid) begin
                    state     <= BEAT_IDLE;
                    res_valid <= 1'b1;
                end
                default:   state <= BEAT_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/struct_beat_unit.sv
// Structure beat unit top: captures one beat command, issues one predicated
// vector-block request, and returns the merged load result.
// Assumes the memory answers each accepted request with exactly one
// response. Alignment and faults are left to the memory side.
module struct_beat_unit #(
    parameter int AW         = 32,
    parameter int IMM_W      = 6,
    parameter int VLEN_BYTES = 16,
    localparam int DW        = 8 * VLEN_BYTES,
    localparam int SIZE_W    = $clog2(VLEN_BYTES) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  op_store,
    input  logic                  op_use_imm,
    input  logic [1:0]            op_esz,
    input  logic [2:0]            op_nregs,
    input  logic [1:0]            op_part,
    input  logic [AW-1:0]         op_base,
    input  logic [AW-1:0]         op_offset,
    input  logic [IMM_W-1:0]      op_imm,
    input  logic [VLEN_BYTES-1:0] op_pred,
    input  logic [DW-1:0]         op_wdata,
    output logic                  busy,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic                  req_write,
    output logic [AW-1:0]         req_addr,
    output logic [SIZE_W-1:0]     req_size,
    output logic [DW-1:0]         req_wdata,
    output logic [VLEN_BYTES-1:0] req_be,
    input  logic                  resp_valid,
    input  logic [DW-1:0]         resp_rdata,
    output logic                  res_valid,
    output logic [DW-1:0]         res_data
);
    logic                  c_store;
    logic                  c_use_imm;
    logic [1:0]            c_esz;
    logic [2:0]            c_nregs;
    logic [1:0]            c_part;
    logic [AW-1:0]         c_base;
    logic [AW-1:0]         c_offset;
    logic [IMM_W-1:0]      c_imm;
    logic [VLEN_BYTES-1:0] c_pred;
    logic [DW-1:0]         c_wdata;

    logic                  accept;
    logic                  resp_take;
    logic [VLEN_BYTES-1:0] byte_act;
    logic [DW-1:0]         st_masked;
    logic [DW-1:0]         ld_masked;

    // Command capture when a beat is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_store   <= 1'b0;
            c_use_imm <= 1'b0;
            c_esz     <= '0;
            c_nregs   <= 3'd2;
            c_part    <= '0;
            c_base    <= '0;
            c_offset  <= '0;
            c_imm     <= '0;
            c_pred    <= '0;
            c_wdata   <= '0;
        end else if (accept) begin
            c_store   <= op_store;
            c_use_imm <= op_use_imm;
            c_esz     <= op_esz;
            c_nregs   <= op_nregs;
            c_part    <= op_part;
            c_base    <= op_base;
            c_offset  <= op_offset;
            c_imm     <= op_imm;
            c_pred    <= op_pred;
            c_wdata   <= op_wdata;
        end
    end

    sbu_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .accept     (accept),
        .resp_take  (resp_take),
        .req_valid  (req_valid),
        .busy       (busy),
        .res_valid  (res_valid)
    );

    sbu_addr_gen #(
        .AW         (AW),
        .IMM_W      (IMM_W),
        .VLEN_BYTES (VLEN_BYTES)
    ) u_addr (
        .base    (c_base),
        .offset  (c_offset),
        .imm     (c_imm),
        .use_imm (c_use_imm),
        .esz     (c_esz),
        .part    (c_part),
        .addr    (req_addr)
    );

    sbu_pred_map #(
        .VLEN_BYTES (VLEN_BYTES)
    ) u_pred (
        .pred     (c_pred),
        .esz      (c_esz),
        .nregs    (c_nregs),
        .part     (c_part),
        .byte_act (byte_act)
    );

    sbu_lane_merge #(
        .VLEN_BYTES (VLEN_BYTES)
    ) u_merge (
        .byte_act (byte_act),
        .st_in    (c_wdata),
        .ld_in    (resp_rdata),
        .st_out   (st_masked),
        .ld_out   (ld_masked)
    );

    // Request fields driven from the captured command.
    assign req_write = c_store;
    assign req_size  = SIZE_W'(VLEN_BYTES);
    assign req_wdata = st_masked;
    assign req_be    = byte_act;

    // Result capture at response time; a store returns zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data <= '0;
        end else if (resp_take) begin
            res_data <= c_store ? '0 : ld_masked;
        end
    end

endmodule

// File: rtl/struct_beat_unit_chk.sv
// Checker for the structure beat unit: protocol and masking properties
// observed at the top-level ports. Bound into every instance of the top.
module struct_beat_unit_chk #(
    parameter int AW         = 32,
    parameter int VLEN_BYTES = 16,
    localparam int DW        = 8 * VLEN_BYTES,
    localparam int SIZE_W    = $clog2(VLEN_BYTES) + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic                  req_write,
    input logic [AW-1:0]         req_addr,
    input logic [SIZE_W-1:0]     req_size,
    input logic [DW-1:0]         req_wdata,
    input logic [VLEN_BYTES-1:0] req_be,
    input logic                  resp_valid,
    input logic                  res_valid
);
    logic [DW-1:0] be_bits;

    // Byte enables widened to bit lanes.
    always_comb begin
        for (int b = 0; b < VLEN_BYTES; b++) begin
            be_bits[8*b +: 8] = {8{req_be[b]}};
        end
    end

    assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

    assert_size_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_size == SIZE_W'(VLEN_BYTES));

    assert_store_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> ((req_wdata & ~be_bits) == '0));

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_be)
                                       && $stable(req_wdata) && $stable(req_write)));

    assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

    assert_res_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(resp_valid && busy && !req_valid));

    assert_res_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

endmodule

bind struct_beat_unit struct_beat_unit_chk #(
    .AW         (AW),
    .VLEN_BYTES (VLEN_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .resp_valid (resp_valid),
    .res_valid  (res_valid)
);

// File: tb/struct_beat_unit_tb.sv
module struct_beat_unit_tb;
    localparam int VB = 16;
    localparam int AW = 32;
    localparam int IW = 6;
    localparam int DW = 8 * VB;
    localparam int SW = $clog2(VB) + 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, start, op_store, op_use_imm;
    logic [1:0]    op_esz, op_part;
    logic [2:0]    op_nregs;
    logic [AW-1:0] op_base, op_offset;
    logic [IW-1:0] op_imm;
    logic [VB-1:0] op_pred;
    logic [DW-1:0] op_wdata;
    logic          busy, req_valid, req_ready, req_write;
    logic [AW-1:0] req_addr;
    logic [SW-1:0] req_size;
    logic [DW-1:0] req_wdata, resp_rdata, res_data;
    logic [VB-1:0] req_be;
    logic          resp_valid, res_valid;

    struct_beat_unit #(.AW(AW), .IMM_W(IW), .VLEN_BYTES(VB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_store(op_store),
        .op_use_imm(op_use_imm), .op_esz(op_esz), .op_nregs(op_nregs),
        .op_part(op_part), .op_base(op_base), .op_offset(op_offset),
        .op_imm(op_imm), .op_pred(op_pred), .op_wdata(op_wdata),
        .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .req_be(req_be), .resp_valid(resp_valid),
        .resp_rdata(resp_rdata), .res_valid(res_valid), .res_data(res_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Current command as the bench intends it
    logic          c_store, c_imm;
    logic [1:0]    c_esz, c_r;
    logic [2:0]    c_n;
    logic [AW-1:0] c_base, c_off;
    logic [IW-1:0] c_immv;
    logic [VB-1:0] c_pred;
    logic [DW-1:0] c_wdata;

    task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [VB-1:0] exp_mask();
        logic [VB-1:0] m;
        int eb = 1 << c_esz;
        int ec = VB / eb;
        for (int b = 0; b < VB; b++) begin
            int idx = (int'(c_r) * ec + b / eb) / int'(c_n);
            m[b] = c_pred[idx];
        end
        return m;
    endfunction

    function automatic logic [AW-1:0] exp_addr();
        int sv = int'($signed(c_immv));
        logic [AW-1:0] a = c_base + AW'(int'(c_r) * VB);
        if (c_imm) a = a + AW'(sv * VB);
        else       a = a + (c_off * AW'(1 << c_esz));
        return a;
    endfunction

    function automatic logic [DW-1:0] apply_mask(logic [DW-1:0] d);
        logic [VB-1:0] m = exp_mask();
        logic [DW-1:0] o;
        for (int b = 0; b < VB; b++) o[8*b +: 8] = m[b] ? d[8*b +: 8] : 8'h00;
        return o;
    endfunction

    task automatic set_cmd(logic st, logic im, logic [1:0] esz, logic [2:0] n, logic [1:0] r,
                           logic [AW-1:0] base, logic [AW-1:0] off, logic [IW-1:0] imv,
                           logic [VB-1:0] pred, logic [DW-1:0] wd);
        c_store = st; c_imm = im; c_esz = esz; c_n = n; c_r = r;
        c_base = base; c_off = off; c_immv = imv; c_pred = pred; c_wdata = wd;
    endtask

    // Starts right after a negedge; returns at the negedge where the request is up.
    task automatic drive_start();
        op_store = c_store; op_use_imm = c_imm; op_esz = c_esz; op_nregs = c_n;
        op_part = c_r; op_base = c_base; op_offset = c_off; op_imm = c_immv;
        op_pred = c_pred; op_wdata = c_wdata;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_req(string tag);
        chk("R8", {tag, " req_valid"}, DW'(req_valid), DW'(1));
        chk(c_imm ? "R2" : "R3", {tag, " addr"}, DW'(req_addr), DW'(exp_addr()));
        chk("R4", {tag, " size"}, DW'(req_size), DW'(VB));
        chk("R5", {tag, " byte enables"}, DW'(req_be), DW'(exp_mask()));
        chk("R7", {tag, " write flag"}, DW'(req_write), DW'(c_store));
        if (c_store) chk("R7", {tag, " wdata"}, req_wdata, apply_mask(c_wdata));
    endtask

    // Ends at the negedge where res_valid must be high.
    task automatic serve(int rdly, int pdly, logic [DW-1:0] rdata, string tag);
        for (int k = 0; k < rdly; k++) begin
            @(negedge clk);
            chk("R8", {tag, " held valid"}, DW'(req_valid), DW'(1));
            chk("R8", {tag, " held addr"}, DW'(req_addr), DW'(exp_addr()));
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk("R8", {tag, " dropped"}, DW'(req_valid), DW'(0));
        chk("R8", {tag, " busy"}, DW'(busy), DW'(1));
        for (int k = 0; k < pdly; k++) begin
            @(negedge clk);
            chk("R9", {tag, " no early result"}, DW'(res_valid), DW'(0));
        end
        resp_valid = 1'b1;
        resp_rdata = rdata;
        @(negedge clk);
        resp_valid = 1'b0;
        chk("R9", {tag, " res_valid"}, DW'(res_valid), DW'(1));
        chk(c_store ? "R9" : "R6", {tag, " res_data"}, res_data,
            c_store ? '0 : apply_mask(rdata));
    endtask

    task automatic idle_check(string tag);
        @(negedge clk);
        chk("R9", {tag, " pulse ends"}, DW'(res_valid), DW'(0));
        chk("R8", {tag, " busy clear"}, DW'(busy), DW'(0));
    endtask

    localparam logic [DW-1:0] RD_A = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    localparam logic [DW-1:0] RD_B = 128'h11223344_55667788_99aabbcc_ddeeff01;
    localparam logic [DW-1:0] WD_A = 128'hfedcba98_76543210_01234567_89abcdef;

    task automatic t_reset();
        chk("R1", "busy in reset", DW'(busy), DW'(0));
        chk("R1", "req_valid in reset", DW'(req_valid), DW'(0));
        chk("R1", "res_valid in reset", DW'(res_valid), DW'(0));
    endtask

    task automatic t_struct_index();
        // R5: N=2, byte elements, pred upper half set. Part 0 selects
        // structures 0..7 (all off), part 1 selects 8..15 (all on).
        set_cmd(0, 1, 2'd0, 3'd2, 2'd0, 32'h1000, 0, 6'd0, 16'hFF00, '0);
        drive_start();
        chk("R5", "part0 mask by structure", DW'(req_be), DW'(16'h0000));
        check_req("r5_p0");
        serve(0, 1, RD_A, "r5_p0");
        idle_check("r5_p0");
        set_cmd(0, 1, 2'd0, 3'd2, 2'd1, 32'h1000, 0, 6'd0, 16'hFF00, '0);
        drive_start();
        chk("R5", "part1 mask by structure", DW'(req_be), DW'(16'hFFFF));
        chk("R2", "part1 addr", DW'(req_addr), DW'(32'h1010));
        serve(0, 0, RD_A, "r5_p1");
        idle_check("r5_p1");
    endtask

    task automatic t_load_reg();
        // R3: word elements, N=3, part 2, unaligned base, ready stalls.
        set_cmd(0, 0, 2'd2, 3'd3, 2'd2, 32'h0000_2003, 32'd5, 6'd0, 16'b0110_1011_0011_0101, '0);
        drive_start();
        chk("R3", "reg form addr", DW'(req_addr), DW'(32'h2003 + 32 + 20));
        check_req("r3_load");
        serve(3, 2, RD_B, "r3_load");
        idle_check("r3_load");
    endtask

    task automatic t_store_half();
        // R7: halfword elements, N=4, part 3, positive immediate.
        set_cmd(1, 1, 2'd1, 3'd4, 2'd3, 32'h4000, 0, 6'd2, 16'hA5C3, WD_A);
        drive_start();
        check_req("r7_half");
        serve(1, 0, RD_A, "r7_half");
        idle_check("r7_half");
    endtask

    task automatic t_store_dword_neg();
        // R2/R7: doubleword elements, N=2, negative immediate -3.
        set_cmd(1, 1, 2'd3, 3'd2, 2'd0, 32'h8000, 0, 6'h3D, 16'h0002, WD_A);
        drive_start();
        chk("R2", "negative imm addr", DW'(req_addr), DW'(32'h8000 - 48));
        check_req("r2_neg");
        serve(0, 0, RD_A, "r2_neg");
        idle_check("r2_neg");
    endtask

    task automatic t_start_while_busy();
        // R9: a start while busy must not disturb or queue a request.
        set_cmd(0, 0, 2'd0, 3'd3, 2'd1, 32'h9000, 32'd7, 6'd0, 16'h3C3C, '0);
        drive_start();
        op_base = 32'hDEAD_0000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "busy start ignored addr", DW'(req_addr), DW'(exp_addr()));
        serve(0, 1, RD_B, "r9_busy");
        idle_check("r9_busy");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9", "no queued request", DW'(req_valid), DW'(0));
        end
    endtask

    task automatic t_stray_resp();
        // R10: a response with nothing outstanding yields no result.
        resp_valid = 1'b1;
        resp_rdata = RD_A;
        @(negedge clk);
        resp_valid = 1'b0;
        chk("R10", "stray resp no result", DW'(res_valid), DW'(0));
        @(negedge clk);
        chk("R10", "stray resp still idle", DW'(busy), DW'(0));
    endtask

    task automatic t_overlap();
        // R11: next command accepted in the result cycle.
        set_cmd(0, 0, 2'd1, 3'd2, 2'd1, 32'hA000, 32'd3, 6'd0, 16'h00F0, '0);
        drive_start();
        check_req("r11_a");
        serve(0, 0, RD_A, "r11_a");
        set_cmd(1, 1, 2'd2, 3'd4, 2'd2, 32'hB000, 0, 6'd1, 16'h1234, WD_A);
        drive_start();
        chk("R11", "next request follows", DW'(req_valid), DW'(1));
        check_req("r11_b");
        serve(2, 1, RD_B, "r11_b");
        idle_check("r11_b");
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; req_ready = 1'b0; resp_valid = 1'b0;
        resp_rdata = '0; op_store = 0; op_use_imm = 0; op_esz = 0; op_nregs = 3'd2;
        op_part = 0; op_base = 0; op_offset = 0; op_imm = 0; op_pred = 0; op_wdata = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_struct_index();
        t_load_reg();
        t_store_half();
        t_store_dword_neg();
        t_start_while_busy();
        t_stray_resp();
        t_overlap();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule